// File: doc/BRIEF.md
# Quad DAC Command Decoder and Latch Bank

This block sits behind a serial receiver that has already assembled a 16-bit command word. When the receiver pulses a one-cycle valid strobe, the block decodes the word's top four bits and acts on four converter channels. Each channel holds a staging register and an output register, so a new code can be prepared without disturbing the live output. The same command can instead write the output register directly, or move the staged code into it. A command can address a single channel or all four at once.

A separate command class leaves both registers alone and changes a 2-bit per-channel output mode. The mode tells the analog stage to drive normally, to float, or to terminate through a low or a high resistance. The code width is a parameter, 8, 10 or 12 bits. The block produces only the four output-register codes and the four mode codes. Conversion and termination happen elsewhere.

Top module: `quad_dac_regbank`

## Requirements
- R1: While reset is high, and after it, every staging register, every output register and every mode is zero until a command changes it. A transfer issued right after reset therefore leaves its output at zero.
- R2: Opcode (word bits 15:12) 0b00cc writes the data code into both registers of channel cc (0=A … 3=D). The output changes on that edge, and the other channels are untouched.
- R3: Opcode 0b01cc writes only the staging register of channel cc. Every output code stays unchanged.
- R4: Opcode 0b10cc copies the staging register of channel cc into its output register. Bits 11:0 of the word have no effect.
- R5: Opcode 0b1100 writes the data code into the staging and output registers of all four channels.
- R6: Opcode 0b1101 writes the data code into all four staging registers only. Opcode 0b1110 copies every staging register into its output register.
- R7: Opcode 0b1111 sets a mode from bits 1:0 (00 drive, 01 float, 10 low-ohm termination, 11 high-ohm termination). If bit 4 is set, the mode goes to all channels; otherwise it goes to the channel in bits 3:2. This command changes no code. No other opcode changes any mode.
- R8: The data code is left-justified: it is word bits 11 down to 12-RES_BITS, and any lower bits are ignored for data.
- R9: When the valid strobe is low, no output code and no mode changes, whatever the word input holds.
- R10: Output codes are packed with channel A in the least significant RES_BITS. Modes are packed the same way, two bits per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe marking cmd_word as a complete command |
| cmd_word | input | 16 | Command word: opcode in bits 15:12, then the data or mode field |
| dac_code_o | output | 4*RES_BITS | Output-register codes, channel A lowest |
| out_mode_o | output | 8 | Output mode per channel, channel A in bits 1:0 |

## Verification
The vector sequence mixes the four command classes on different channels. The checks tell the following cases apart:
- A staged load is told from a direct write because the output stays unchanged until a later transfer.
- A transfer is told from a direct write because its data field carries a different value than the staged one.
- The broadcast forms are told from single-channel forms because every slice must change.
- Power-down words are told from data writes because the codes must hold while only the selected mode slice moves.

A second instance at 8-bit resolution shows that the code is taken from the top of the field, even when the low bits are non-zero. Directed steps show that:
- a changing word with the strobe low has no effect;
- a reset in mid-run clears the staging registers, so a later transfer yields zero.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NUM_CH   = 4;
    localparam int WORD_W   = 16;
    localparam int FIELD_W  = 12;
    localparam int MODE_W   = 2;
    localparam int CHSEL_W  = $clog2(NUM_CH);

    typedef enum logic [1:0] {
        OM_DRIVE    = 2'b00,
        OM_FLOAT    = 2'b01,
        OM_LOW_OHM  = 2'b10,
        OM_HIGH_OHM = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        GRP_DIRECT = 2'b00,
        GRP_STAGE  = 2'b01,
        GRP_MOVE   = 2'b10,
        GRP_GLOBAL = 2'b11
    } op_group_e;

    typedef enum logic [1:0] {
        GOP_ALL_DIRECT = 2'b00,
        GOP_ALL_STAGE  = 2'b01,
        GOP_ALL_MOVE   = 2'b10,
        GOP_POWER      = 2'b11
    } global_op_e;

    typedef struct packed {
        logic [NUM_CH-1:0] wr_stage;
        logic [NUM_CH-1:0] wr_out;
        logic [NUM_CH-1:0] move;
        logic [NUM_CH-1:0] set_mode;
        out_mode_e         mode;
    } chan_ctl_t;

    function automatic logic [NUM_CH-1:0] chan_onehot(input logic [CHSEL_W-1:0] sel);
        logic [NUM_CH-1:0] r;
        r = '0;
        r[sel] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/qdac_decoder.sv
module qdac_decoder
    import qdac_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output chan_ctl_t         ctl,
    output logic [RES_BITS-1:0] code
);
    localparam int OP_LSB  = FIELD_W;
    localparam int CODE_LO = FIELD_W - RES_BITS;

    op_group_e         grp;
    global_op_e        gop;
    logic [NUM_CH-1:0] sel_one;
    logic [NUM_CH-1:0] pd_sel;

    assign grp     = op_group_e'(word[WORD_W-1 -: 2]);
    assign gop     = global_op_e'(word[OP_LSB+1:OP_LSB]);
    assign sel_one = chan_onehot(word[OP_LSB+1:OP_LSB]);
    assign pd_sel  = word[4] ? {NUM_CH{1'b1}} : chan_onehot(word[3:2]);
    assign code    = word[FIELD_W-1:CODE_LO];

    always_comb begin
        ctl          = '0;
        ctl.mode     = out_mode_e'(word[1:0]);
        if (valid) begin
            unique case (grp)
                GRP_DIRECT: begin
                    ctl.wr_stage = sel_one;
                    ctl.wr_out   = sel_one;
                end
                GRP_STAGE:  ctl.wr_stage = sel_one;
                GRP_MOVE:   ctl.move     = sel_one;
                GRP_GLOBAL: begin
                    unique case (gop)
                        GOP_ALL_DIRECT: begin
                            ctl.wr_stage = {NUM_CH{1'b1}};
                            ctl.wr_out   = {NUM_CH{1'b1}};
                        end
                        GOP_ALL_STAGE: ctl.wr_stage = {NUM_CH{1'b1}};
                        GOP_ALL_MOVE:  ctl.move     = {NUM_CH{1'b1}};
                        GOP_POWER:     ctl.set_mode = pd_sel;
                        default:       ctl.set_mode = '0;
                    endcase
                end
                default: ctl.wr_stage = '0;
            endcase
        end
    end

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
    import qdac_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stage,
    input  logic                wr_out,
    input  logic                move,
    input  logic                set_mode,
    input  out_mode_e           mode_in,
    input  logic [RES_BITS-1:0] code_in,
    output logic [RES_BITS-1:0] out_code,
    output out_mode_e           mode_q
);
    logic [RES_BITS-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            out_code <= '0;
            mode_q   <= OM_DRIVE;
        end else begin
            if (wr_stage) begin
                stage_q <= code_in;
            end
            if (wr_out) begin
                out_code <= code_in;
            end else if (move) begin
                out_code <= stage_q;
            end
            if (set_mode) begin
                mode_q <= mode_in;
            end
        end
    end

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
    import qdac_pkg::*;
#(
    parameter int RES_BITS = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [15:0]                cmd_word,
    output logic [4*RES_BITS-1:0]      dac_code_o,
    output logic [4*MODE_W-1:0]        out_mode_o
);
    chan_ctl_t           ctl;
    logic [RES_BITS-1:0] code;

    qdac_decoder #(.RES_BITS(RES_BITS)) u_dec (
        .valid (cmd_valid),
        .word  (cmd_word),
        .ctl   (ctl),
        .code  (code)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        out_mode_e mode_ch;

        qdac_channel #(.RES_BITS(RES_BITS)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_stage (ctl.wr_stage[ch]),
            .wr_out   (ctl.wr_out[ch]),
            .move     (ctl.move[ch]),
            .set_mode (ctl.set_mode[ch]),
            .mode_in  (ctl.mode),
            .code_in  (code),
            .out_code (dac_code_o[ch*RES_BITS +: RES_BITS]),
            .mode_q   (mode_ch)
        );

        assign out_mode_o[ch*MODE_W +: MODE_W] = mode_ch;
    end

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker #(
    parameter int RES_BITS = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_valid,
    input logic [15:0]           cmd_word,
    input logic [4*RES_BITS-1:0] dac_code_o,
    input logic [7:0]            out_mode_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (dac_code_o == '0) && (out_mode_o == '0)); // R1

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(dac_code_o) && $stable(out_mode_o)); // R9

    AST_STAGE_HOLDS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_word[15:14] == 2'b01) |=> $stable(dac_code_o)); // R3

    AST_POWER_HOLDS_CODES: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_word[15:12] == 4'hF) |=> $stable(dac_code_o)); // R7

    AST_DATA_HOLDS_MODES: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_word[15:12] != 4'hF) |=> $stable(out_mode_o)); // R7

    for (genvar ch = 0; ch < 4; ch++) begin : g_ch
        AST_DIRECT_LOADS: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_word[15:12] == 4'(ch))
            |=> dac_code_o[ch*RES_BITS +: RES_BITS] == $past(cmd_word[11 -: RES_BITS])); // R2

        AST_BROADCAST_LOADS: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_word[15:12] == 4'hC)
            |=> dac_code_o[ch*RES_BITS +: RES_BITS] == $past(cmd_word[11 -: RES_BITS])); // R5

        AST_POWER_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
            (cmd_valid && cmd_word[15:12] == 4'hF && (cmd_word[4] || cmd_word[3:2] == 2'(ch)))
            |=> out_mode_o[ch*2 +: 2] == $past(cmd_word[1:0])); // R7
    end

endmodule

bind quad_dac_regbank qdac_checker #(.RES_BITS(RES_BITS)) u_qdac_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .dac_code_o (dac_code_o),
    .out_mode_o (out_mode_o)
);

// File: tb/tb_quad_dac_regbank.sv
module tb_quad_dac_regbank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [47:0] dac_code_o;
    logic [7:0]  out_mode_o;

    logic        v8 = 1'b0;
    logic [15:0] w8 = '0;
    logic [31:0] dac8;
    logic [7:0]  mode8;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    quad_dac_regbank #(.RES_BITS(12)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .dac_code_o(dac_code_o), .out_mode_o(out_mode_o)
    );

    quad_dac_regbank #(.RES_BITS(8)) dut_r8 (
        .clk(clk), .rst(rst), .cmd_valid(v8), .cmd_word(w8),
        .dac_code_o(dac8), .out_mode_o(mode8)
    );

    // {req, word, codes D..A, modes D..A}
    localparam logic [79:0] VEC [0:15] = '{
        {8'd2,  16'h0123, 48'h000000000123, 8'h00},
        {8'd2,  16'h1456, 48'h000000456123, 8'h00},
        {8'd3,  16'h6ABC, 48'h000000456123, 8'h00},
        {8'd4,  16'hA777, 48'h000ABC456123, 8'h00},
        {8'd3,  16'h7DEF, 48'h000ABC456123, 8'h00},
        {8'd5,  16'hC555, 48'h555555555555, 8'h00},
        {8'd4,  16'hB000, 48'h555555555555, 8'h00},
        {8'd6,  16'hD9A0, 48'h555555555555, 8'h00},
        {8'd4,  16'h8FFF, 48'h5555555559A0, 8'h00},
        {8'd6,  16'hE000, 48'h9A09A09A09A0, 8'h00},
        {8'd7,  16'hF005, 48'h9A09A09A09A0, 8'h04},
        {8'd7,  16'hF00E, 48'h9A09A09A09A0, 8'h84},
        {8'd7,  16'hF013, 48'h9A09A09A09A0, 8'hFF},
        {8'd7,  16'hF010, 48'h9A09A09A09A0, 8'h00},
        {8'd7,  16'hF00B, 48'h9A09A09A09A0, 8'h30},
        {8'd10, 16'h0FFF, 48'h9A09A09A0FFF, 8'h30}
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send8(input logic [15:0] w);
        @(negedge clk);
        v8 = 1'b1;
        w8 = w;
        @(negedge clk);
        v8 = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dac_code_o == '0, "R1 codes in reset", 64'(dac_code_o), 64'h0);
        chk(out_mode_o == '0, "R1 modes in reset", 64'(out_mode_o), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(dac_code_o == '0 && out_mode_o == '0, "R1 after reset release",
            64'({dac_code_o, out_mode_o}), 64'h0);

        // R2 R3 R4 R5 R6 R7 R10: vector walk
        for (int i = 0; i < 16; i++) begin
            send(VEC[i][71:56]);
            chk(dac_code_o == VEC[i][55:8], $sformatf("R%0d codes vec%0d", VEC[i][79:72], i),
                64'(dac_code_o), 64'(VEC[i][55:8]));
            chk(out_mode_o == VEC[i][7:0], $sformatf("R%0d modes vec%0d", VEC[i][79:72], i),
                64'(out_mode_o), 64'(VEC[i][7:0]));
        end

        // R9: strobe low, word toggling
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            cmd_word = 16'hC000 ^ 16'(k * 16'h1111);
        end
        @(negedge clk);
        chk(dac_code_o == 48'h9A09A09A0FFF, "R9 codes with strobe low",
            64'(dac_code_o), 64'h9A09A09A0FFF);
        chk(out_mode_o == 8'h30, "R9 modes with strobe low", 64'(out_mode_o), 64'h30);

        // R8: 8-bit instance takes the top of the field
        send8(16'h0ABF);
        send8(16'h1CD5);
        chk(dac8 == 32'h0000CDAB, "R8 left-justified code", 64'(dac8), 64'h0000CDAB);
        send8(16'hF01F);
        chk(mode8 == 8'hFF && dac8 == 32'h0000CDAB, "R7 power-all on narrow instance",
            64'({dac8, mode8}), 64'h0000CDABFF);

        // R1: mid-run reset clears staging too
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(dac_code_o == '0 && out_mode_o == '0, "R1 mid-run reset",
            64'({dac_code_o, out_mode_o}), 64'h0);
        send(16'hE000);
        chk(dac_code_o == '0, "R1 transfer after reset gives zero", 64'(dac_code_o), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule